// File: doc/BRIEF.md
# Programmable Wrap Timer

This block is an 8-bit up-counter that returns to zero after it matches a programmable modulo value. Each time it returns to zero it raises an overflow flag. When interrupts are enabled, the flag drives a level interrupt request. Software controls the block through a small synchronous register bus with three registers: control/status, modulo and counter.

The counter advances only on cycles where the external count tick is high and the timer is running. The timer leaves reset stopped. Software can start it, stop it, or force the count back to zero. The overflow flag is hard to clear by accident: a plain write of zero does not clear it unless a read of the status register, taken while the flag was set, came before that write. Two other actions also clear the flag: a counter-reset write and any write to the modulo register.

Top module: `wrap_timer`

## Requirements
- R1: After reset the control/status register (address 0) reads 0x10, meaning the stop bit is set and the flag and enable are clear. The modulo register (address 1) and the counter register (address 2) read 0x00, and irq is low.
- R2: The counter at address 2 increases by one on a clock edge only when tick is 1 and the stop bit (control bit 4) is 0. The stop value used is the one held before that edge.
- R3: When an advancing edge finds the counter equal to the modulo value, the counter becomes 0x00 and the overflow flag (control bit 7) becomes 1.
- R4: With a modulo value of 0x00, every advancing edge produces an overflow and the counter stays at 0x00.
- R5: A write to address 0 with bit 7 = 0 clears the flag only if a read of address 0 came earlier, taken while the flag was 1. Any write to address 0 or address 1 uses up that earlier read. A write of zero with no such read leaves the flag at 1.
- R6: Writing address 0 with bit 5 = 1 sets the counter to 0x00 and clears the flag. Bit 5 always reads 0, and writing 0 to it has no effect.
- R7: Any write to the modulo register clears the flag.
- R8: While stopped, the counter holds its value. After bit 4 is cleared, counting resumes from the held value.
- R9: irq is 1 exactly when both the flag and the interrupt enable (control bit 6) are 1. It stays high until the flag is cleared.
- R10: If an overflow and a clearing action occur in the same cycle, the flag ends up set.
- R11: Writes to the counter address are ignored. Control bits 3..0 read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable pulse |
| addr | input | 2 | Register address (0 control, 1 modulo, 2 counter) |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (arms the flag-clear sequence) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets several corner cases, and each has a visible symptom when the design gets it wrong:
- A blind write of zero to the flag: a design that skips the armed-read check clears the flag early and drops irq.
- An overflow that lands in the same cycle as a modulo write: if the clear wins, the event is lost.
- A modulo value of zero: an off-by-one comparison shows up as a counter that climbs instead of staying at zero.
- Stop and resume: a design that reloads zero loses the held count.
- Writes to the read-only counter address: any effect appears as a changed count.

Long random stretches of bus traffic mixed with ticks are also compared against the reference model on every cycle.

// File: rtl/wrap_timer_pkg.sv
// Package: shared address map and control-bit positions for the wrap timer.
// Assumes an 8-bit control/status register; bit positions are fixed by the map.
package wrap_timer_pkg;
    localparam int AW = 2;

    typedef enum logic [AW-1:0] {
        ADR_CTRL = 2'd0,
        ADR_MOD  = 2'd1,
        ADR_CNT  = 2'd2,
        ADR_NONE = 2'd3
    } wt_addr_e;

    // Control/status bit positions
    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_RST  = 5;
    localparam int B_STOP = 4;
    localparam int B_HI   = 4;   // lowest control bit carrying a field
endpackage

// File: rtl/wrap_timer_decode.sv
// Module: turns the bus strobes and address into per-register access pulses.
// Assumes single-cycle strobes; the counter address produces no write pulse.
module wrap_timer_decode
    import wrap_timer_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          ctrl_wr,
    output logic          ctrl_rd,
    output logic          mod_wr
);
    // Purpose: decode address into access strobes
    always_comb begin
        ctrl_wr = wr_en && (wt_addr_e'(addr) == ADR_CTRL);
        ctrl_rd = rd_en && (wt_addr_e'(addr) == ADR_CTRL);
        mod_wr  = wr_en && (wt_addr_e'(addr) == ADR_MOD);
    end
endmodule

// File: rtl/wrap_timer_count.sv
// Module: modulo register and the up-counter that wraps after matching it.
// Assumes adv already folds in tick and the run state; clr has priority.
module wrap_timer_count #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          clr,
    input  logic          mod_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] modv,
    output logic          wrap
);
    logic hit;

    // Purpose: detect the match that ends a count period
    always_comb begin
        hit  = (cnt == modv);
        wrap = adv && hit && !clr;
    end

    // Purpose: hold the software-programmed modulo value
    always_ff @(posedge clk) begin
        if (!rst_n)
            modv <= '0;
        else if (mod_wr)
            modv <= wdata;
    end

    // Purpose: advance, wrap or force the counter to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (adv)
            cnt <= hit ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/wrap_timer_status.sv
// Module: overflow flag with its read-armed clear sequence, interrupt enable
// and stop bit. Assumes wd_hi carries control bits 7..4 of the write data.
module wrap_timer_status
    import wrap_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       ctrl_rd,
    input  logic       mod_wr,
    input  logic [3:0] wd_hi,
    input  logic       wrap,
    output logic       flag,
    output logic       ie,
    output logic       stop,
    output logic       clr
);
    logic armed;
    logic drop;

    // Purpose: form the counter-reset request and the flag-clear condition
    always_comb begin
        clr  = ctrl_wr && wd_hi[B_RST - B_HI];
        drop = clr || mod_wr ||
               (ctrl_wr && armed && !wd_hi[B_FLAG - B_HI]);
    end

    // Purpose: overflow flag, where setting beats every clear source
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (wrap)
            flag <= 1'b1;
        else if (drop)
            flag <= 1'b0;
    end

    // Purpose: remember a status read taken while the flag was up
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (ctrl_wr || mod_wr)
            armed <= 1'b0;
        else if (ctrl_rd && flag)
            armed <= 1'b1;
    end

    // Purpose: software-writable enable and stop bits; stop leaves reset set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie   <= 1'b0;
            stop <= 1'b1;
        end else if (ctrl_wr) begin
            ie   <= wd_hi[B_IE - B_HI];
            stop <= wd_hi[B_STOP - B_HI];
        end
    end
endmodule

// File: rtl/wrap_timer.sv
// Module: top of the wrap timer, tying decode, counter and status together and
// producing the read data mux and the level interrupt. Assumes a synchronous bus.
module wrap_timer
    import wrap_timer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          irq
);
    logic          ctrl_wr, ctrl_rd, mod_wr;
    logic          flag_q, ie_q, stop_q, clr;
    logic          adv, wrap;
    logic [DW-1:0] cnt_q, mod_q;
    logic [DW-1:0] ctrl_view;

    wrap_timer_decode u_dec (
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .mod_wr  (mod_wr)
    );

    wrap_timer_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .ctrl_rd (ctrl_rd),
        .mod_wr  (mod_wr),
        .wd_hi   (wdata[B_FLAG:B_HI]),
        .wrap    (wrap),
        .flag    (flag_q),
        .ie      (ie_q),
        .stop    (stop_q),
        .clr     (clr)
    );

    // Purpose: count only on ticks while running
    always_comb adv = tick && !stop_q;

    wrap_timer_count #(.DW(DW)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (adv),
        .clr    (clr),
        .mod_wr (mod_wr),
        .wdata  (wdata),
        .cnt    (cnt_q),
        .modv   (mod_q),
        .wrap   (wrap)
    );

    // Purpose: assemble the control/status view with zeros in unused bits
    always_comb begin
        ctrl_view         = '0;
        ctrl_view[B_FLAG] = flag_q;
        ctrl_view[B_IE]   = ie_q;
        ctrl_view[B_STOP] = stop_q;
    end

    // Purpose: read mux and level interrupt
    always_comb begin
        case (wt_addr_e'(addr))
            ADR_CTRL: rdata = ctrl_view;
            ADR_MOD:  rdata = mod_q;
            ADR_CNT:  rdata = cnt_q;
            default:  rdata = '0;
        endcase
        irq = flag_q && ie_q;
    end
endmodule

// File: rtl/wrap_timer_chk.sv
// Module: property checker for the wrap timer, attached by bind.
// Assumes it observes the top's ports and its held counter/status state.
module wrap_timer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    addr,
    input logic          wr_en,
    input logic          rst_bit,
    input logic [DW-1:0] cnt,
    input logic [DW-1:0] modv,
    input logic          flag,
    input logic          stop,
    input logic          irq
);
    logic rst_wr;
    logic go;
    always_comb begin
        rst_wr = wr_en && (addr == 2'd0) && rst_bit;
        go     = tick && !stop && !rst_wr;
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        go && (cnt != modv) |=> cnt == $past(cnt) + 1'b1); // R2
    AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        go && (cnt == modv) |=> flag && (cnt == '0)); // R3
    AST_RST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (cnt == '0)); // R6
    AST_MOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == 2'd1) && !(go && cnt == modv) |=> !flag); // R7
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !rst_wr |=> $stable(cnt)); // R8
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R9
endmodule

bind wrap_timer wrap_timer_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .addr    (addr),
    .wr_en   (wr_en),
    .rst_bit (wdata[5]),
    .cnt     (cnt_q),
    .modv    (mod_q),
    .flag    (flag_q),
    .stop    (stop_q),
    .irq     (irq)
);

// File: tb/test_wrap_timer.sv
module test_wrap_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_cnt = 0, m_mod = 0;
    bit m_flag = 0, m_ie = 0, m_stop = 1, m_arm = 0;

    always #10 clk = ~clk;

    wrap_timer i_wrap_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int model_read(int a);
        case (a)
            0: return (int'(m_flag) << 7) | (int'(m_ie) << 6) | (int'(m_stop) << 4);
            1: return m_mod;
            2: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive, compare against the model, then advance the model.
    task automatic cyc(string tag, int a, bit w, bit r, int d, bit t);
        bit cw, mw, cr, rw, adv, wrp, nflag;
        addr = a[1:0]; wr_en = w; rd_en = r; wdata = d[7:0]; tick = t;
        #1;
        chk({tag, " rdata"}, int'(rdata), model_read(a));
        chk({tag, " irq"}, int'(irq), int'(m_flag && m_ie));
        @(posedge clk);
        cw  = w && a == 0;
        mw  = w && a == 1;
        cr  = r && a == 0;
        rw  = cw && d[5];
        adv = t && !m_stop;
        wrp = adv && (m_cnt == m_mod) && !rw;
        nflag = m_flag;
        if (rw || mw || (cw && !d[7] && m_arm)) nflag = 0;
        if (wrp) nflag = 1;
        if (cw || mw) m_arm = 0;
        else if (cr && m_flag) m_arm = 1;
        m_flag = nflag;
        if (rw) m_cnt = 0;
        else if (adv) m_cnt = wrp ? 0 : (m_cnt + 1) % 256;
        if (mw) m_mod = d & 8'hff;
        if (cw) begin m_ie = d[6]; m_stop = d[4]; end
        @(negedge clk);
    endtask

    task automatic idle(string tag, int n, bit t);
        for (int i = 0; i < n; i++) cyc(tag, 2, 0, 0, 0, t);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        addr = 2'd0; #1; chk("R1 ctrl", int'(rdata), 8'h10);
        addr = 2'd1; #1; chk("R1 mod", int'(rdata), 0);
        addr = 2'd2; #1; chk("R1 cnt", int'(rdata), 0);
        chk("R1 irq", int'(irq), 0);
        // R8: stopped after reset, ticks ignored
        idle("R8", 3, 1);
        addr = 2'd2; #1; chk("R8 stopped cnt", int'(rdata), 0);
        // R2/R3: modulo 3, run with interrupts
        cyc("R7", 1, 1, 0, 3, 0);
        cyc("R2", 0, 1, 0, 8'h40, 0);
        idle("R2", 3, 1);
        addr = 2'd2; #1; chk("R2 cnt", int'(rdata), 3);
        idle("R3", 1, 1);
        addr = 2'd0; #1; chk("R3 flag", int'(rdata), 8'hC0);
        addr = 2'd2; #1; chk("R3 wrapped", int'(rdata), 0);
        chk("R9 irq high", int'(irq), 1);
        // R5: blind write of zero leaves the flag set
        cyc("R5", 0, 1, 0, 8'h40, 0);
        chk("R5 blind", int'(irq), 1);
        cyc("R5", 0, 0, 1, 0, 0);
        cyc("R5", 0, 1, 0, 8'h40, 0);
        chk("R5 cleared", int'(irq), 0);
        // R8: stop holds, resume from held value
        idle("R8", 2, 1);
        cyc("R8", 0, 1, 0, 8'h50, 0);
        idle("R8", 4, 1);
        addr = 2'd2; #1; chk("R8 held", int'(rdata), 2);
        cyc("R8", 0, 1, 0, 8'h40, 0);
        idle("R8", 1, 1);
        addr = 2'd2; #1; chk("R8 resumed", int'(rdata), 3);
        // R6: counter reset bit
        idle("R6", 1, 1);
        cyc("R6", 0, 1, 0, 8'h60, 0);
        addr = 2'd0; #1; chk("R6 flag and bit5", int'(rdata), 8'h40);
        addr = 2'd2; #1; chk("R6 cnt", int'(rdata), 0);
        // R7: modulo write clears the flag
        idle("R7", 4, 1);
        chk("R7 flag up", int'(irq), 1);
        cyc("R7", 1, 1, 0, 5, 0);
        chk("R7 cleared", int'(irq), 0);
        // R10: overflow in the same cycle as a modulo write
        idle("R10", 5, 1);
        cyc("R10", 1, 1, 0, 5, 1);
        chk("R10 set wins", int'(irq), 1);
        // R4: modulo zero
        cyc("R4", 1, 1, 0, 0, 0);
        idle("R4", 3, 1);
        addr = 2'd2; #1; chk("R4 cnt", int'(rdata), 0);
        chk("R4 flag", int'(irq), 1);
        // R11: counter writes ignored, spare address reads zero
        cyc("R11", 1, 1, 0, 8'h20, 0);
        idle("R11", 3, 1);
        cyc("R11", 2, 1, 0, 8'h55, 0);
        addr = 2'd2; #1; chk("R11 cnt", int'(rdata), 3);
        addr = 2'd3; #1; chk("R11 spare", int'(rdata), 0);
        // random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int a = $urandom_range(0, 3);
            bit w = ($urandom_range(0, 9) == 0);
            bit r = ($urandom_range(0, 3) == 0);
            int d = $urandom_range(0, 255);
            if (a == 0 && w && $urandom_range(0, 3) != 0) d = d & 8'hC0;
            if (a == 1) d = d & 8'h0f;
            cyc("R2 random", a, w, r, d, $urandom_range(0, 1));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule